// File: doc/BRIEF.md
# Channel-Status Capture Double Buffer

This block sits behind an AES3 or S/PDIF receiver front end. For every decoded subframe it receives one channel-status bit, a flag saying which subchannel (A or B) the subframe belongs to, and a strobe marking the frame that opens a 192-frame channel-status block. It keeps the leading five bytes of each subchannel's channel-status block. That is 40 bits per subchannel and 80 bits in all.

Capture runs in two stages. Incoming bits land in a staging image, one bit position at a time, and each byte fills MSB-first. When bit 39 of both subchannels is in, the complete staging image is copied into a host image in a single cycle, and a one-cycle update pulse is raised. Register reads are decoded from the host image only, so a reader never observes a mix of two blocks. A block that is cut short by an early block-start strobe is never copied.

The same bits also leave the block serially on one pin. A short queue holds the recovered bits, and every transition of the output frame clock, rising or falling, presents the next queued bit.

Top module: `chs_capture`

## Requirements
- R1: After reset, every register address reads 0x00, `blk_upd` is low and `ser_c` is low.
- R2: Within a block, capture position n (n = 0..39) of a subchannel is stored in byte n/8, bit 7-(n mod 8). The first bit of the block therefore lands in the MSB of byte 0.
- R3: Reads of addresses 0x23..0x27 return subchannel A bytes 0..4. Reads of 0x28..0x2C return subchannel B bytes 0..4. Every other address reads 0x00.
- R4: The host image changes only as a whole. This happens one clock after the B subframe at position 39 is captured, provided the A subframe at position 39 of the same block was captured earlier. `blk_upd` is high for exactly that one cycle.
- R5: If a block-start strobe arrives before both subchannels reach position 39, the partial block is dropped. There is no copy and no pulse.
- R6: Subframes at positions 40..191 are not stored. Subframes seen after reset and before the first block-start strobe are not stored.
- R7: `blk_start` is honoured only together with a valid A subframe (`sf_sub`=0). That subframe is captured as position 0. The position advances after each B subframe (`sf_sub`=1).
- R8: On each cycle where `lrck` differs from its value on the previous clock, the oldest queued bit moves to `ser_c`, in arrival order. With an empty queue, `ser_c` holds its value, so it stays low until a subframe has arrived.
- R9: The serial queue holds SER_DEPTH bits (default 4). A bit that arrives while the queue is full and nothing is leaving is discarded.
- R10: When a block is copied in the same cycle as the next block's first A subframe, the host receives the finished block and the new bit goes to staging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | One-cycle strobe for a decoded subframe |
| sf_sub | input | 1 | Subchannel of the subframe: 0 = A, 1 = B |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| blk_start | input | 1 | Frame carries the block-start preamble |
| lrck | input | 1 | Output frame clock, synchronous to clk |
| rd_addr | input | AW (8) | Register read address |
| rd_data | output | 8 | Read data from the host image |
| blk_upd | output | 1 | One-cycle pulse when the host image is refreshed |
| ser_c | output | 1 | Serial channel-status output |

## Verification
Two events can share one clock. The first is the copy of a finished block into the host image. The second is the capture of the next block's opening A subframe, with its start strobe, into staging. The bench provokes this by driving the start-marked A subframe on the very clock after the B subframe at position 39. It then reads the host registers, which must still show the old block, and counts exactly one update pulse. After that it completes the new block and checks that the bit captured during the copy cycle sits at the MSB of byte 0.

// File: rtl/chs_pkg.sv
package chs_pkg;
   typedef enum logic {SUB_A = 1'b0, SUB_B = 1'b1} sub_e;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/chs_index.sv
module chs_index #(
   parameter int NBITS      = 40,
   parameter int BLK_FRAMES = 192,
   parameter int IW         = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sf_valid,
   input  logic          sf_sub,
   input  logic          blk_start,
   output logic          cap_en,
   output logic [IW-1:0] cap_idx,
   output logic          restart
);
   import chs_pkg::*;
   localparam logic [IW-1:0] LAST_FRAME = IW'(BLK_FRAMES - 1);
   localparam logic [IW-1:0] CAP_LIMIT  = IW'(NBITS);

   logic          synced;
   logic [IW-1:0] fidx;

   always_comb begin
      restart = sf_valid && (sf_sub == SUB_A) && blk_start;
      cap_idx = restart ? '0 : fidx;
      cap_en  = sf_valid && (synced || restart) && (cap_idx < CAP_LIMIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         synced <= 1'b0;
         fidx   <= '0;
      end else if (restart) begin
         synced <= 1'b1;
         fidx   <= '0;
      end else if (sf_valid && synced && (sf_sub == SUB_B)) begin
         if (fidx == LAST_FRAME) begin
            synced <= 1'b0;
            fidx   <= '0;
         end else begin
            fidx <= fidx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/chs_stage.sv
module chs_stage #(
   parameter int NBYTES = 5,
   parameter int IW     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_en,
   input  logic                          cap_sub,
   input  logic [IW-1:0]                 cap_idx,
   input  logic                          cap_bit,
   input  logic                          restart,
   output logic [2*NBYTES-1:0][7:0]      img,
   output logic                          xfer_req
);
   import chs_pkg::*;
   localparam int NBITS = NBYTES * BYTE_W;
   localparam int NLOC  = 2 * NBYTES;
   localparam logic [IW-1:0] LAST_BIT = IW'(NBITS - 1);

   logic          a_done;
   logic [2:0]    bit_sel;
   logic [IW-4:0] byte_sel;

   assign bit_sel  = cap_idx[2:0];
   assign byte_sel = cap_idx[IW-1:3];

   for (genvar g = 0; g < NLOC; g++) begin : g_loc
      localparam logic          LOC_SUB  = (g >= NBYTES);
      localparam logic [IW-4:0] LOC_BYTE = (IW-3)'(g % NBYTES);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            img[g] <= '0;
         end else if (cap_en && (cap_sub == LOC_SUB) && (byte_sel == LOC_BYTE)) begin
            img[g][3'd7 - bit_sel] <= cap_bit;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_done   <= 1'b0;
         xfer_req <= 1'b0;
      end else begin
         xfer_req <= cap_en && (cap_sub == SUB_B) && (cap_idx == LAST_BIT) && a_done;
         if (restart) begin
            a_done <= 1'b0;
         end else if (cap_en && (cap_idx == LAST_BIT)) begin
            a_done <= (cap_sub == SUB_A);
         end
      end
   end
endmodule

// File: rtl/chs_host.sv
module chs_host #(
   parameter int          NBYTES = 5,
   parameter int          AW     = 8,
   parameter logic [7:0]  BASE_A = 8'h23
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      xfer,
   input  logic [2*NBYTES-1:0][7:0]  stage_img,
   input  logic [AW-1:0]             rd_addr,
   output logic [7:0]                rd_data,
   output logic                      upd
);
   localparam int NLOC = 2 * NBYTES;

   logic [NLOC-1:0][7:0] host;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host <= '0;
         upd  <= 1'b0;
      end else begin
         upd <= xfer;
         if (xfer) host <= stage_img;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NLOC; i++) begin
         if (rd_addr == AW'(int'(BASE_A) + i)) rd_data = host[i];
      end
   end
endmodule

// File: rtl/chs_serial.sv
module chs_serial #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_bit,
   input  logic lrck,
   output logic ser_c
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [DEPTH-1:0] q, qn;
   logic [CW-1:0]    cnt, cn;
   logic             lr_q, edge_hit, pop;

   assign edge_hit = lrck ^ lr_q;
   assign pop      = edge_hit && (cnt != '0);

   always_comb begin
      qn = q;
      cn = cnt;
      if (pop) begin
         qn = q >> 1;
         cn = cnt - 1'b1;
      end
      if (push && (cn != FULL)) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == cn) qn[i] = push_bit;
         end
         cn = cn + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      lr_q <= lrck;
      if (!rst_n) begin
         q     <= '0;
         cnt   <= '0;
         ser_c <= 1'b0;
      end else begin
         q   <= qn;
         cnt <= cn;
         if (pop) ser_c <= q[0];
      end
   end
endmodule

// File: rtl/chs_capture.sv
module chs_capture #(
   parameter int          NBYTES     = 5,
   parameter int          BLK_FRAMES = 192,
   parameter int          AW         = 8,
   parameter logic [7:0]  BASE_A     = 8'h23,
   parameter int          SER_DEPTH  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sf_valid,
   input  logic          sf_sub,
   input  logic          sf_cbit,
   input  logic          blk_start,
   input  logic          lrck,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          blk_upd,
   output logic          ser_c
);
   localparam int NBITS = NBYTES * 8;
   localparam int IW    = $clog2(BLK_FRAMES);

   if (NBYTES < 1 || NBITS > BLK_FRAMES) begin : g_bad_size
      $error("chs_capture: NBYTES out of range");
   end
   if (SER_DEPTH < 1) begin : g_bad_depth
      $error("chs_capture: SER_DEPTH must be positive");
   end
   if (int'(BASE_A) + 2 * NBYTES > (1 << AW)) begin : g_bad_map
      $error("chs_capture: register window exceeds address space");
   end

   logic                     cap_en, restart, xfer_req;
   logic [IW-1:0]            cap_idx;
   logic [2*NBYTES-1:0][7:0] stage_img;

   chs_index #(.NBITS(NBITS), .BLK_FRAMES(BLK_FRAMES), .IW(IW)) u_index (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_sub(sf_sub),
      .blk_start(blk_start), .cap_en(cap_en), .cap_idx(cap_idx), .restart(restart)
   );

   chs_stage #(.NBYTES(NBYTES), .IW(IW)) u_stage (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_sub(sf_sub),
      .cap_idx(cap_idx), .cap_bit(sf_cbit), .restart(restart),
      .img(stage_img), .xfer_req(xfer_req)
   );

   chs_host #(.NBYTES(NBYTES), .AW(AW), .BASE_A(BASE_A)) u_host (
      .clk(clk), .rst_n(rst_n), .xfer(xfer_req), .stage_img(stage_img),
      .rd_addr(rd_addr), .rd_data(rd_data), .upd(blk_upd)
   );

   chs_serial #(.DEPTH(SER_DEPTH)) u_serial (
      .clk(clk), .rst_n(rst_n), .push(sf_valid), .push_bit(sf_cbit),
      .lrck(lrck), .ser_c(ser_c)
   );
endmodule

// File: rtl/chs_capture_chk.sv
module chs_capture_chk #(
   parameter int          NBYTES = 5,
   parameter int          AW     = 8,
   parameter logic [7:0]  BASE_A = 8'h23
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sf_valid,
   input logic          sf_sub,
   input logic          lrck,
   input logic [AW-1:0] rd_addr,
   input logic [7:0]    rd_data,
   input logic          blk_upd,
   input logic          ser_c
);
   localparam int LAST_ADDR = int'(BASE_A) + 2 * NBYTES - 1;

   logic seen_sf;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_sf <= 1'b0;
      else if (sf_valid) seen_sf <= 1'b1;
   end

   assert_upd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_upd |=> !blk_upd);

   assert_upd_after_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_upd |-> ($past(sf_valid, 2) && $past(sf_sub, 2)));

   assert_host_atomic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_upd && $stable(rd_addr)) |-> $stable(rd_data));

   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(rd_addr) < int'(BASE_A)) || (int'(rd_addr) > LAST_ADDR)) |-> (rd_data == 8'h00));

   assert_ser_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_c) |-> ($past(lrck) != $past(lrck, 2)));

   assert_ser_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_sf |-> !ser_c);
endmodule

bind chs_capture chs_capture_chk #(.NBYTES(NBYTES), .AW(AW), .BASE_A(BASE_A)) u_chk (
   .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_sub(sf_sub), .lrck(lrck),
   .rd_addr(rd_addr), .rd_data(rd_data), .blk_upd(blk_upd), .ser_c(ser_c)
);

// File: tb/chs_capture_tb.sv
`timescale 1ns/1ps
module chs_capture_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sf_valid = 1'b0, sf_sub = 1'b0, sf_cbit = 1'b0, blk_start = 1'b0;
   logic       lrck = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       blk_upd, ser_c;

   int checks = 0, errors = 0, upd_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   chs_capture u_dut (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_sub(sf_sub),
      .sf_cbit(sf_cbit), .blk_start(blk_start), .lrck(lrck),
      .rd_addr(rd_addr), .rd_data(rd_data), .blk_upd(blk_upd), .ser_c(ser_c)
   );

   always @(negedge clk) if (rst_n && blk_upd) upd_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input int sub, input int b);
      return 8'((k * 37 + sub * 91 + b * 53 + 5) & 255);
   endfunction

   function automatic logic bitof(input int k, input int sub, input int n);
      logic [7:0] v;
      v = pat(k, sub, n / 8);
      return v[7 - (n % 8)];
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // called at a negedge, returns at the next negedge
   task automatic send_sf(input logic sub, input logic b, input logic st);
      sf_valid = 1'b1; sf_sub = sub; sf_cbit = b; blk_start = st;
      @(negedge clk);
      sf_valid = 1'b0; blk_start = 1'b0;
   endtask

   task automatic send_frame(input int k, input int f, input logic st);
      logic ba, bb;
      ba = (f < 40) ? bitof(k, 0, f) : f[0];
      bb = (f < 40) ? bitof(k, 1, f) : ~f[0];
      send_sf(1'b0, ba, st);
      @(negedge clk);
      send_sf(1'b1, bb, 1'b0);
      @(negedge clk);
   endtask

   task automatic check_host(input int k, input string req);
      for (int s = 0; s < 2; s++)
         for (int b = 0; b < 5; b++) begin
            rd_addr = 8'(8'h23 + s * 5 + b);
            #1 chk(req, rd_data, pat(k, s, b));
         end
   endtask

   task automatic t_reset_R1();
      for (int a = 8'h20; a < 8'h30; a++) begin
         rd_addr = 8'(a);
         #1 chk("R1 reset read", rd_data, 0);
      end
      chk("R1 blk_upd", blk_upd, 0);
      chk("R1 ser_c", ser_c, 0);
   endtask

   task automatic t_unsynced_R6();
      int u0 = upd_cnt;
      for (int f = 0; f < 45; f++) send_frame(9, f, 1'b0);
      repeat (3) @(negedge clk);
      chk("R6 no pulse before start", upd_cnt - u0, 0);
      rd_addr = 8'h23; #1 chk("R6 host untouched", rd_data, 0);
   endtask

   task automatic t_full_block_R2_R4(input int k);
      int u0 = upd_cnt;
      for (int f = 0; f < 39; f++) send_frame(k, f, f == 0);
      rd_addr = 8'h23; #1 chk("R4 host unchanged mid block", rd_data, 0);
      send_sf(1'b0, bitof(k, 0, 39), 1'b0);
      @(negedge clk);
      sf_valid = 1'b1; sf_sub = 1'b1; sf_cbit = bitof(k, 1, 39);
      @(posedge clk); #1;
      chk("R4 no pulse at capture edge", blk_upd, 0);
      @(negedge clk); sf_valid = 1'b0;
      @(posedge clk); #1;
      chk("R4 pulse one clock later", blk_upd, 1);
      @(posedge clk); #1;
      chk("R4 pulse is single", blk_upd, 0);
      @(negedge clk);
      check_host(k, "R2 R3 block contents");
      for (int f = 40; f < 192; f++) send_frame(k, f, 1'b0);
      chk("R6 tail frames no extra pulse", upd_cnt - u0, 1);
      check_host(k, "R6 tail frames ignored");
   endtask

   task automatic t_unmapped_R3();
      rd_addr = 8'h22; #1 chk("R3 below window", rd_data, 0);
      rd_addr = 8'h2D; #1 chk("R3 above window", rd_data, 0);
      rd_addr = 8'hFF; #1 chk("R3 top address", rd_data, 0);
   endtask

   task automatic t_partial_R5_R7(input int kold, input int knew);
      int u0 = upd_cnt;
      for (int f = 0; f < 20; f++) send_frame(knew + 50, f, f == 0);
      // B-frame start must be ignored (R7)
      send_sf(1'b1, 1'b1, 1'b1); @(negedge clk);
      for (int f = 0; f < 39; f++) send_frame(knew, f, f == 0);
      // mid-block restart at position 39 of A only
      send_sf(1'b0, 1'b1, 1'b0); @(negedge clk);
      chk("R5 no copy of partial block", upd_cnt - u0, 0);
      check_host(kold, "R5 host keeps old block");
      for (int f = 0; f < 40; f++) send_frame(knew, f, f == 0);
      repeat (2) @(negedge clk);
      chk("R7 restarted block copied once", upd_cnt - u0, 1);
      check_host(knew, "R7 restarted block contents");
   endtask

   task automatic t_coincide_R10(input int kold, input int knew);
      int u0 = upd_cnt;
      for (int f = 0; f < 39; f++) send_frame(kold, f, f == 0);
      send_sf(1'b0, bitof(kold, 0, 39), 1'b0); @(negedge clk);
      send_sf(1'b1, bitof(kold, 1, 39), 1'b0);
      send_sf(1'b0, bitof(knew, 0, 0), 1'b1);   // same clock as the copy
      @(negedge clk);
      chk("R10 one pulse", upd_cnt - u0, 1);
      check_host(kold, "R10 host holds finished block");
      send_sf(1'b1, bitof(knew, 1, 0), 1'b0); @(negedge clk);
      for (int f = 1; f < 40; f++) send_frame(knew, f, 1'b0);
      repeat (2) @(negedge clk);
      chk("R10 second pulse", upd_cnt - u0, 2);
      check_host(knew, "R10 new block incl copy-cycle bit");
   endtask

   task automatic toggle_expect(input int exp, input string req);
      @(negedge clk); lrck = ~lrck;
      @(posedge clk); #1 chk(req, ser_c, exp);
   endtask

   task automatic t_serial_R8_R9();
      do_reset();
      rd_addr = 8'h23; #1 chk("R1 host cleared by reset", rd_data, 0);
      chk("R1 ser_c after reset", ser_c, 0);
      toggle_expect(0, "R8 empty queue holds low");
      toggle_expect(0, "R8 empty queue holds low");
      @(negedge clk);
      send_sf(1'b0, 1'b1, 1'b0); send_sf(1'b1, 1'b0, 1'b0); send_sf(1'b0, 1'b1, 1'b0);
      toggle_expect(1, "R8 first bit rising edge");
      toggle_expect(0, "R8 second bit falling edge");
      toggle_expect(1, "R8 third bit");
      toggle_expect(1, "R8 hold when empty");
      @(negedge clk);
      send_sf(1'b0, 1'b0, 1'b0); send_sf(1'b1, 1'b1, 1'b0);
      send_sf(1'b0, 1'b0, 1'b0); send_sf(1'b1, 1'b1, 1'b0);
      send_sf(1'b0, 1'b0, 1'b0); send_sf(1'b1, 1'b0, 1'b0);
      toggle_expect(0, "R9 queued bit 1");
      toggle_expect(1, "R9 queued bit 2");
      toggle_expect(0, "R9 queued bit 3");
      toggle_expect(1, "R9 queued bit 4");
      toggle_expect(1, "R9 overflow bits dropped");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_R1();
      t_unsynced_R6();
      t_full_block_R2_R4(1);
      t_unmapped_R3();
      t_partial_R5_R7(1, 2);
      t_coincide_R10(3, 4);
      t_serial_R8_R9();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule